// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Flags

This block produces the two interrupt flags that let the two sides of a shared 1024-byte memory signal each other. The two highest locations act as mailboxes: the second-highest one belongs to port A and the highest one belongs to port B. A write by one port into the other port's mailbox raises the other port's flag. The owning port lowers its flag again by reading its own mailbox. The mailbox bytes stay ordinary memory cells held in the array outside this block, so the message format is up to software. When software never uses the mailboxes, those two cells behave like any other location.

Each port presents a select, a write strobe, a read (output) enable and an address, all sampled on the clock and all active low where marked `_n`. Each port also has a stall input driven by the collision arbiter. When a port's stall is low, the access that port makes has no effect on either flag. The flags are registered and driven at all times, and they are active low.

Top module: `mbx_irq_flags`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both `pa_irq_n` and `pb_irq_n` are high (no pending message).
- R2: If port B makes a write to address 0x3FE (`pb_sel_n`=0, `pb_wr_n`=0) with `pb_stall_n`=1, then `pa_irq_n` is low after the next clock edge.
- R3: If port A makes a write to address 0x3FF (`pa_sel_n`=0, `pa_wr_n`=0) with `pa_stall_n`=1, then `pb_irq_n` is low after the next clock edge.
- R4: If port A accesses 0x3FE with `pa_sel_n`=0 and `pa_oe_n`=0 and `pa_stall_n`=1, then `pa_irq_n` returns high after the next edge, whatever the level of `pa_wr_n`.
- R5: If port B accesses 0x3FF with `pb_sel_n`=0 and `pb_oe_n`=0 and `pb_stall_n`=1, then `pb_irq_n` returns high after the next edge, whatever the level of `pb_wr_n`.
- R6: A set access whose writing port has its stall input low leaves the flag unchanged. A clear access whose reading port has its stall input low also leaves the flag unchanged.
- R7: When a set and a clear of the same flag happen in the same cycle, the flag ends up low (set wins).
- R8: No other access changes a flag. This covers accesses to addresses other than the mailboxes, a read of the partner's mailbox, and a write by a port to its own mailbox while its output enable is high.
- R9: A port with `*_sel_n` high has no effect on either flag, whatever its other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pa_sel_n | input | 1 | Port A select, active low |
| pa_wr_n | input | 1 | Port A write strobe, low = write |
| pa_oe_n | input | 1 | Port A output enable, active low |
| pa_addr | input | 10 | Port A address |
| pa_stall_n | input | 1 | Port A arbiter stall, low = access blocked |
| pb_sel_n | input | 1 | Port B select, active low |
| pb_wr_n | input | 1 | Port B write strobe, low = write |
| pb_oe_n | input | 1 | Port B output enable, active low |
| pb_addr | input | 10 | Port B address |
| pb_stall_n | input | 1 | Port B arbiter stall, low = access blocked |
| pa_irq_n | output | 1 | Message pending for port A, active low |
| pb_irq_n | output | 1 | Message pending for port B, active low |

## Verification
Each flag is a single state bit, and that bit drives its output pin directly through one register. A wrong flag state therefore shows on its interrupt pin in the very next cycle, and it stays visible until a legitimate set or clear overwrites it. A decode error, such as a wrong mailbox address, a swapped stall qualifier or a reversed priority, shows one edge after the offending access. The bench compares both pins after every cycle against a reference model, using directed mailbox traffic followed by random traffic that is biased towards the two top addresses.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  // Side index: 0 = port A, 1 = port B.
  // A side's own mailbox is the cell it reads to clear its flag.
  // Port A owns the second-highest cell and port B owns the highest.
  function automatic int unsigned own_box(int unsigned aw, int unsigned side);
    return (32'd1 << aw) - 32'd2 + side;
  endfunction

  // The partner of a side is the other side.
  function automatic int unsigned partner(int unsigned side);
    return 32'd1 - side;
  endfunction

  // Next value of a pending bit: a set overrides a clear.
  function automatic logic next_pending(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/mbx_port_dec.sv
module mbx_port_dec #(
  parameter int unsigned AW   = 10,
  parameter int unsigned SIDE = 0
) (
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic          stall_n,
  output logic          post_ev,
  output logic          take_ev
);
  import mbx_pkg::*;

  localparam logic [AW-1:0] OWN_BOX  = AW'(own_box(AW, SIDE));
  localparam logic [AW-1:0] PEER_BOX = AW'(own_box(AW, partner(SIDE)));

  logic granted;
  assign granted = ~sel_n & stall_n;

  // A write into the partner's mailbox posts a message for the partner.
  assign post_ev = granted & ~wr_n & (addr == PEER_BOX);
  // A read-enabled access to the side's own mailbox takes the message.
  assign take_ev = granted & ~oe_n & (addr == OWN_BOX);
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  import mbx_pkg::*;

  logic pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= next_pending(pending, set, clr);
  end

  assign irq_n = ~pending;
endmodule

// File: rtl/mbx_irq_flags.sv
module mbx_irq_flags #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pa_sel_n,
  input  logic          pa_wr_n,
  input  logic          pa_oe_n,
  input  logic [AW-1:0] pa_addr,
  input  logic          pa_stall_n,
  input  logic          pb_sel_n,
  input  logic          pb_wr_n,
  input  logic          pb_oe_n,
  input  logic [AW-1:0] pb_addr,
  input  logic          pb_stall_n,
  output logic          pa_irq_n,
  output logic          pb_irq_n
);
  localparam int unsigned NSIDE = 2;

  logic          sel_n   [NSIDE];
  logic          wr_n    [NSIDE];
  logic          oe_n    [NSIDE];
  logic [AW-1:0] addr    [NSIDE];
  logic          stall_n [NSIDE];
  logic          irq_n   [NSIDE];

  // Named events, exposed for the checker.
  logic [NSIDE-1:0] post_ev;
  logic [NSIDE-1:0] take_ev;

  assign sel_n[0]   = pa_sel_n;
  assign sel_n[1]   = pb_sel_n;
  assign wr_n[0]    = pa_wr_n;
  assign wr_n[1]    = pb_wr_n;
  assign oe_n[0]    = pa_oe_n;
  assign oe_n[1]    = pb_oe_n;
  assign addr[0]    = pa_addr;
  assign addr[1]    = pb_addr;
  assign stall_n[0] = pa_stall_n;
  assign stall_n[1] = pb_stall_n;

  for (genvar s = 0; s < NSIDE; s++) begin : g_side
    mbx_port_dec #(.AW(AW), .SIDE(s)) u_dec (
      .sel_n   (sel_n[s]),
      .wr_n    (wr_n[s]),
      .oe_n    (oe_n[s]),
      .addr    (addr[s]),
      .stall_n (stall_n[s]),
      .post_ev (post_ev[s]),
      .take_ev (take_ev[s])
    );

    // A side's flag is set by its partner's post and cleared by its own take.
    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (post_ev[NSIDE-1-s]),
      .clr   (take_ev[s]),
      .irq_n (irq_n[s])
    );
  end

  assign pa_irq_n = irq_n[0];
  assign pb_irq_n = irq_n[1];
endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
  parameter int unsigned AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pa_sel_n,
  input logic          pa_wr_n,
  input logic          pa_oe_n,
  input logic [AW-1:0] pa_addr,
  input logic          pa_stall_n,
  input logic          pb_sel_n,
  input logic          pb_wr_n,
  input logic          pb_oe_n,
  input logic [AW-1:0] pb_addr,
  input logic          pb_stall_n,
  input logic          pa_irq_n,
  input logic          pb_irq_n,
  input logic [1:0]    post_ev,
  input logic [1:0]    take_ev
);
  localparam logic [AW-1:0] BOX_A = AW'((1 << AW) - 2);
  localparam logic [AW-1:0] BOX_B = AW'((1 << AW) - 1);

  logic b_posts, a_posts, a_takes, b_takes;
  assign b_posts = !pb_sel_n && !pb_wr_n && pb_addr == BOX_A && pb_stall_n;
  assign a_posts = !pa_sel_n && !pa_wr_n && pa_addr == BOX_B && pa_stall_n;
  assign a_takes = !pa_sel_n && !pa_oe_n && pa_addr == BOX_A && pa_stall_n;
  assign b_takes = !pb_sel_n && !pb_oe_n && pb_addr == BOX_B && pb_stall_n;

  // R2
  a_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    b_posts |=> !pa_irq_n);
  // R3
  b_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_posts |=> !pb_irq_n);
  // R4
  a_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_takes && !b_posts) |=> pa_irq_n);
  // R5
  b_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_takes && !a_posts) |=> pb_irq_n);
  // R8
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_ev[1] && !take_ev[0]) |=> $stable(pa_irq_n));
  // R8
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_ev[0] && !take_ev[1]) |=> $stable(pb_irq_n));
  // R9
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pa_sel_n && pb_sel_n) |-> (post_ev == 2'b00 && take_ev == 2'b00));
endmodule

bind mbx_irq_flags mbx_irq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pa_sel_n   (pa_sel_n),
  .pa_wr_n    (pa_wr_n),
  .pa_oe_n    (pa_oe_n),
  .pa_addr    (pa_addr),
  .pa_stall_n (pa_stall_n),
  .pb_sel_n   (pb_sel_n),
  .pb_wr_n    (pb_wr_n),
  .pb_oe_n    (pb_oe_n),
  .pb_addr    (pb_addr),
  .pb_stall_n (pb_stall_n),
  .pa_irq_n   (pa_irq_n),
  .pb_irq_n   (pb_irq_n),
  .post_ev    (post_ev),
  .take_ev    (take_ev)
);

// File: tb/sim_mbx_irq_flags.sv
module sim_mbx_irq_flags;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pa_sel_n = 1'b1, pa_wr_n = 1'b1, pa_oe_n = 1'b1, pa_stall_n = 1'b1;
  logic pb_sel_n = 1'b1, pb_wr_n = 1'b1, pb_oe_n = 1'b1, pb_stall_n = 1'b1;
  logic [9:0] pa_addr = '0, pb_addr = '0;
  logic pa_irq_n, pb_irq_n;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // Reference state: 1 = message pending.
  logic m_a = 1'b0, m_b = 1'b0;
  logic [1:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  mbx_irq_flags u0 (.*);

  task automatic check(string tag, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: irq_n {a,b} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of access and pushes the expected pins.
  task automatic drive(
    input logic as, input logic aw, input logic ao, input logic [9:0] aa, input logic ak,
    input logic bs, input logic bw, input logic bo, input logic [9:0] ba, input logic bk,
    input string tag);
    logic set_a, clr_a, set_b, clr_b;
    @(negedge clk);
    pa_sel_n = as; pa_wr_n = aw; pa_oe_n = ao; pa_addr = aa; pa_stall_n = ak;
    pb_sel_n = bs; pb_wr_n = bw; pb_oe_n = bo; pb_addr = ba; pb_stall_n = bk;
    set_a = !bs && !bw && ba == 10'h3FE && bk;
    set_b = !as && !aw && aa == 10'h3FF && ak;
    clr_a = !as && !ao && aa == 10'h3FE && ak;
    clr_b = !bs && !bo && ba == 10'h3FF && bk;
    if (set_a) m_a = 1'b1; else if (clr_a) m_a = 1'b0;
    if (set_b) m_b = 1'b1; else if (clr_b) m_b = 1'b0;
    exp_q.push_back({~m_a, ~m_b});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    drive(1,1,1,10'h000,1, 1,1,1,10'h000,1, tag);
  endtask

  // Monitor: compares one cycle after each driven access.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) check(tag_q.pop_front(), {pa_irq_n, pb_irq_n}, exp_q.pop_front());
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    check("R1 during reset", {pa_irq_n, pb_irq_n}, 2'b11);
    // Traffic during reset must not leave a pending flag.
    pb_sel_n = 0; pb_wr_n = 0; pb_addr = 10'h3FE;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset holds", {pa_irq_n, pb_irq_n}, 2'b11);
    @(negedge clk);
    pb_sel_n = 1; pb_wr_n = 1;
    rst_n = 1'b1;
    idle("R1 after reset");
    drive(1,1,1,10'h000,1, 0,0,1,10'h3FE,1, "R2 B posts to A");
    idle("R8 idle hold");
    drive(0,0,1,10'h123,1, 1,1,1,10'h000,1, "R8 other address");
    drive(0,1,0,10'h3FE,0, 1,1,1,10'h000,1, "R6 clear blocked by A stall");
    drive(0,0,0,10'h3FE,1, 1,1,1,10'h000,1, "R4 clear with write level low");
    drive(0,0,1,10'h3FF,0, 1,1,1,10'h000,1, "R6 set blocked by A stall");
    drive(0,0,1,10'h3FF,1, 1,1,1,10'h000,1, "R3 A posts to B");
    drive(1,1,1,10'h000,1, 0,1,0,10'h3FE,1, "R8 B reads partner box");
    drive(1,1,1,10'h000,1, 1,0,0,10'h3FF,1, "R9 B deselected");
    drive(1,1,1,10'h000,1, 0,1,0,10'h3FF,1, "R5 B takes");
    drive(0,0,1,10'h3FF,1, 0,1,0,10'h3FF,1, "R7 set beats clear on B");
    drive(1,1,1,10'h000,1, 0,0,1,10'h3FE,0, "R6 set blocked by B stall");
    drive(0,1,0,10'h3FE,1, 0,0,1,10'h3FE,1, "R7 set beats clear on A");
    drive(0,0,1,10'h3FE,1, 1,1,1,10'h000,1, "R8 A writes own box, oe high");
    drive(1,0,0,10'h3FE,1, 1,1,1,10'h000,1, "R9 A deselected");
    drive(1,1,1,10'h000,1, 0,0,0,10'h3FF,1, "R5 B takes with write low");
    drive(0,1,0,10'h3FE,1, 1,1,1,10'h000,1, "R4 A takes");
    for (int i = 0; i < 300; i++) begin
      logic [9:0] aa, ba;
      aa = ($urandom % 3 == 0) ? 10'($urandom) : (10'h3FE | 10'($urandom % 2));
      ba = ($urandom % 3 == 0) ? 10'($urandom) : (10'h3FE | 10'($urandom % 2));
      drive(1'($urandom), 1'($urandom), 1'($urandom), aa, 1'($urandom % 4 != 0),
            1'($urandom), 1'($urandom), 1'($urandom), ba, 1'($urandom % 4 != 0),
            "R8 random traffic");
    end
    idle("R8 final idle");
    repeat (3) @(posedge clk);
    #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule